// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block is a synchronous controller for a 1M x 16 extended-data-out DRAM. A host presents word requests through a valid/ready handshake. Each request carries a 20-bit word address, a read/write flag, a two-bit byte enable and 16 bits of write data. The controller splits the address into a 10-bit row half and a 10-bit column half and sends them in turn on a shared address bus. It drives the active-low row strobe, the two byte column strobes, write enable and output enable. Read data is captured into a register and returned with a one-cycle response pulse.

After an access the row stays open, so a later request to the same row needs only a column cycle. A request to another row closes the page first. So does an open row that reaches its age limit. The minimum row-active width and the precharge interval are always honoured before a new row opens. Every strobe interval is a parameter given in nanoseconds and is rounded up to whole clocks at elaboration. The same RTL therefore fits other speed grades and clock rates.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row half `req_addr[19:10]` is on `dram_addr` when `dram_ras_n` falls. The column half `req_addr[9:0]` is on `dram_addr` when the column strobes fall.
- R2: A write asserts `dram_ucas_n` only if `req_be[1]` (data bits 15:8) is set, and `dram_lcas_n` only if `req_be[0]` (bits 7:0) is set. The enabled strobes fall together and do not change while low. Bytes that are not enabled keep their stored value.
- R3: A read asserts both column strobes together and drives `dram_oe_n` low during the column-low phase. `dram_oe_n` is never low while `dram_we_n` is low or while the controller drives the data pins.
- R4: A write is an early write. `dram_we_n` is low and the write data is driven at least one cycle before the column strobe falls, with `dram_oe_n` high.
- R5: The column strobe falls no sooner than the row-to-column delay count after `dram_ras_n` falls (2 cycles by default).
- R6: `dram_ras_n` stays high for at least the precharge count before it falls again (4 cycles by default). This also applies after reset.
- R7: `dram_ras_n` stays low for at least the row-active count (6 cycles). The column strobe stays low for at least the column-width count (1 cycle).
- R8: Within one open row, successive column-strobe falls are at least the page-cycle count apart (3 cycles).
- R9: A request to the currently open row causes no new row activation.
- R10: A request to a different row, or to a closed page, causes exactly one new row activation.
- R11: `dram_ras_n` is never low for more than the open-row limit (10000 cycles). An idle open row is closed before that limit.
- R12: Read data is sampled no earlier than the access count after the column strobe falls (4 cycles). It is returned on `rsp_rdata` with `rsp_valid` high for one cycle.
- R13: During and right after reset, all DRAM strobes are high, the data pins are released and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in bits 19:10, column in bits 9:0 |
| req_be | input | 2 | Byte enable, bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
Full-word writes followed by reads of the same word show whether the row and column halves reach the device in the right phases. Upper-only and lower-only writes to one word, then a read, separate correct per-byte strobing from whole-word strobing. Back-to-back requests to the same row and requests that alternate between rows separate page reuse from needless re-activation, and they stress the precharge and row-active intervals. A long idle gap shows that an open row is closed by its age limit. Random mixes over a few rows and columns then cover the interleavings of hits, misses, byte masks and read/write turnarounds.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRE    = 3'd1,
    ST_ACT    = 3'd2,
    ST_COLSET = 3'd3,
    ST_CASLO  = 3'd4,
    ST_CASHI  = 3'd5
  } edo_state_e;

  // Round a nanosecond interval up to whole clocks, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Strobe-high cycles so that setup + low + high covers the page cycle.
  function automatic int cas_high_cyc(input int lo_cyc, input int pc_cyc);
    return max2(1, pc_cyc - 1 - lo_cyc);
  endfunction

  function automatic int bits_for(input int value);
    return $clog2(value + 2);
  endfunction

endpackage

// File: rtl/edo_ras_timer.sv
module edo_ras_timer #(
  parameter int AGE_MAX = 10000,
  parameter int PRE_MAX = 4,
  localparam int AGE_W = $clog2(AGE_MAX + 2),
  localparam int PRE_W = $clog2(PRE_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  output logic [AGE_W-1:0] age,
  output logic [PRE_W-1:0] pre
);
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(AGE_MAX);
  localparam logic [PRE_W-1:0] PRE_SAT = PRE_W'(PRE_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '0;
      pre <= '0;
    end else if (ras_n) begin
      age <= '0;
      if (pre != PRE_SAT) pre <= pre + 1'b1;
    end else begin
      pre <= '0;
      if (age != AGE_SAT) age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic             page_open,
  input  logic [ROW_W-1:0] probe_row,
  output logic             hit
);
  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    open_row_q <= '0;
    else if (load) open_row_q <= load_row;
  end

  assign hit = page_open && (open_row_q == probe_row);
endmodule

// File: rtl/edo_cas_drive.sv
module edo_cas_drive #(
  parameter int BE_W = 2
) (
  input  logic            cas_on,
  input  logic            full_word,
  input  logic [BE_W-1:0] be,
  output logic [BE_W-1:0] cas_n
);
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign cas_n[b] = !(cas_on && (full_word || be[b]));
  end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int ROW_W       = 10,
  parameter int DATA_W      = 16,
  parameter int CLK_PS      = 10000,
  parameter int T_RCD_NS    = 14,
  parameter int T_RP_NS     = 40,
  parameter int T_RAS_NS    = 60,
  parameter int T_CAS_NS    = 10,
  parameter int T_PC_NS     = 25,
  parameter int T_ACC_NS    = 35,
  parameter int T_ROWMAX_NS = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [9:0]        dram_addr,
  output logic              dram_ras_n,
  output logic              dram_ucas_n,
  output logic              dram_lcas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int COL_W      = ADDR_W - ROW_W;
  localparam int MUX_W      = max2(ROW_W, COL_W);
  localparam int BE_W       = 2;
  localparam int RCD_CYC    = ns_to_cyc(T_RCD_NS, CLK_PS);
  localparam int RP_CYC     = ns_to_cyc(T_RP_NS, CLK_PS);
  localparam int RAS_CYC    = ns_to_cyc(T_RAS_NS, CLK_PS);
  localparam int CAS_CYC    = ns_to_cyc(T_CAS_NS, CLK_PS);
  localparam int PC_CYC     = ns_to_cyc(T_PC_NS, CLK_PS);
  localparam int ACC_CYC    = ns_to_cyc(T_ACC_NS, CLK_PS);
  localparam int ROWMAX_CYC = ns_to_cyc(T_ROWMAX_NS, CLK_PS);
  localparam int WR_LO      = CAS_CYC;
  localparam int RD_LO      = max2(CAS_CYC, ACC_CYC);
  localparam int WR_HI      = cas_high_cyc(WR_LO, PC_CYC);
  localparam int RD_HI      = cas_high_cyc(RD_LO, PC_CYC);
  localparam int ACCESS_MAX = 1 + max2(RD_LO + RD_HI, WR_LO + WR_HI) + 4;
  localparam int CLOSE_AGE  = max2(RAS_CYC, ROWMAX_CYC - ACCESS_MAX);
  localparam int CNT_MAX    = max2(max2(RCD_CYC, RD_LO), max2(RD_HI, WR_HI));
  localparam int CNT_W      = bits_for(CNT_MAX);
  localparam int AGE_W      = $clog2(ROWMAX_CYC + 2);
  localparam int PRE_W      = $clog2(RP_CYC + 2);

  edo_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ras_n_q;
  logic              pend_q;
  logic              pend_write_q;
  logic [BE_W-1:0]   pend_be_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic [AGE_W-1:0]  ras_age;
  logic [PRE_W-1:0]  pre_age;
  logic [BE_W-1:0]   cas_n;

  // Named internal events.
  logic              page_open;
  logic              row_hit;
  logic              expired;
  logic              ev_accept;
  logic              ev_close;
  logic              ev_activate;
  logic              ev_sample;
  logic              ras_ok;
  logic              pre_ok;
  logic              lo_last;
  logic              hi_last;
  logic [ROW_W-1:0]  req_row;
  logic [ROW_W-1:0]  pend_row;
  logic [COL_W-1:0]  pend_col;

  assign req_row   = req_addr[ADDR_W-1 -: ROW_W];
  assign pend_row  = pend_addr_q[ADDR_W-1 -: ROW_W];
  assign pend_col  = pend_addr_q[COL_W-1:0];
  assign page_open = !ras_n_q;
  assign expired   = page_open && (ras_age >= AGE_W'(CLOSE_AGE));
  assign req_ready = (state_q == ST_IDLE) && !expired;
  assign ev_accept = req_valid && req_ready;
  assign ras_ok    = ras_age >= AGE_W'(RAS_CYC - 1);
  assign pre_ok    = pre_age >= PRE_W'(RP_CYC - 1);
  assign ev_close    = (state_q == ST_PRE) && page_open && ras_ok;
  assign ev_activate = (state_q == ST_PRE) && !page_open && pend_q && pre_ok;
  assign lo_last = cnt_q == (pend_write_q ? CNT_W'(WR_LO - 1) : CNT_W'(RD_LO - 1));
  assign hi_last = cnt_q == (pend_write_q ? CNT_W'(WR_HI - 1) : CNT_W'(RD_HI - 1));
  assign ev_sample = (state_q == ST_CASLO) && !pend_write_q && lo_last;

  edo_ras_timer #(
    .AGE_MAX (ROWMAX_CYC),
    .PRE_MAX (RP_CYC)
  ) u_ras_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .ras_n (ras_n_q),
    .age   (ras_age),
    .pre   (pre_age)
  );

  edo_row_track #(
    .ROW_W (ROW_W)
  ) u_row_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_activate),
    .load_row  (pend_row),
    .page_open (page_open),
    .probe_row (req_row),
    .hit       (row_hit)
  );

  edo_cas_drive #(
    .BE_W (BE_W)
  ) u_cas_drive (
    .cas_on    (state_q == ST_CASLO),
    .full_word (!pend_write_q),
    .be        (pend_be_q),
    .cas_n     (cas_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      ras_n_q      <= 1'b1;
      pend_q       <= 1'b0;
      pend_write_q <= 1'b0;
      pend_be_q    <= '0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (expired) begin
            state_q <= ST_PRE;
          end else if (ev_accept) begin
            pend_q       <= 1'b1;
            pend_write_q <= req_write;
            pend_be_q    <= req_be;
            pend_addr_q  <= req_addr;
            pend_wdata_q <= req_wdata;
            state_q      <= row_hit ? ST_COLSET : ST_PRE;
          end
        end
        ST_PRE: begin
          if (ev_close) begin
            ras_n_q <= 1'b1;
          end else if (ev_activate) begin
            ras_n_q <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_ACT;
          end else if (!page_open && !pend_q) begin
            state_q <= ST_IDLE;
          end
        end
        ST_ACT: begin
          if (cnt_q == CNT_W'(RCD_CYC - 1)) begin
            state_q <= ST_COLSET;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_COLSET: begin
          cnt_q   <= '0;
          state_q <= ST_CASLO;
        end
        ST_CASLO: begin
          if (lo_last) begin
            cnt_q   <= '0;
            state_q <= ST_CASHI;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CASHI: begin
          if (hi_last) begin
            pend_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= ev_sample;
      if (ev_sample) rsp_rdata_q <= dram_dq_in;
    end
  end

  logic col_phase;
  logic row_phase;
  assign col_phase = (state_q == ST_COLSET) || (state_q == ST_CASLO);
  assign row_phase = (state_q == ST_PRE) || (state_q == ST_ACT);

  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_rdata_q;
  assign dram_addr   = row_phase ? MUX_W'(pend_row) : MUX_W'(pend_col);
  assign dram_ras_n  = ras_n_q;
  assign dram_ucas_n = cas_n[1];
  assign dram_lcas_n = cas_n[0];
  assign dram_we_n   = !(pend_write_q && col_phase);
  assign dram_oe_n   = !(!pend_write_q && (state_q == ST_CASLO));
  assign dram_dq_oe  = pend_write_q && col_phase;
  assign dram_dq_out = pend_wdata_q;

endmodule

// File: rtl/edo_ctrl_checker.sv
module edo_ctrl_checker #(
  parameter int RCD_MIN = 2,
  parameter int RP_MIN  = 4,
  parameter int RAS_MIN = 6,
  parameter int ROW_MAX = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic ucas_n,
  input logic lcas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);
  logic        cas_act;
  int unsigned hi_cnt;
  int unsigned lo_cnt;

  assign cas_act = !ucas_n || !lcas_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= 0;
      lo_cnt <= 0;
    end else if (ras_n) begin
      hi_cnt <= hi_cnt + 1;
      lo_cnt <= 0;
    end else begin
      lo_cnt <= lo_cnt + 1;
      hi_cnt <= 0;
    end
  end

  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= RP_MIN);

  a_r7_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_cnt >= RAS_MIN);

  a_r11_row_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> lo_cnt <= ROW_MAX);

  a_r5_row_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_act) |-> (!ras_n && lo_cnt >= RCD_MIN));

  a_r4_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_act) && !we_n) |-> $past(!we_n));

  a_r3_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !dq_oe));

  a_r2_no_stagger: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_act && $past(cas_act)) |-> $stable({ucas_n, lcas_n}));

endmodule

bind edo_page_ctrl edo_ctrl_checker #(
  .RCD_MIN (RCD_CYC),
  .RP_MIN  (RP_CYC),
  .RAS_MIN (RAS_CYC),
  .ROW_MAX (ROWMAX_CYC)
) u_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .ras_n  (dram_ras_n),
  .ucas_n (dram_ucas_n),
  .lcas_n (dram_lcas_n),
  .we_n   (dram_we_n),
  .oe_n   (dram_oe_n),
  .dq_oe  (dram_dq_oe)
);

// File: tb/tb_edo_page_ctrl.sv
module tb_edo_page_ctrl;
  localparam int CLK_PERIOD = 10;

  function automatic int b_ceil(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction

  localparam int E_RCD    = b_ceil(14);
  localparam int E_RP     = b_ceil(40);
  localparam int E_RAS    = b_ceil(60);
  localparam int E_CAS    = b_ceil(10);
  localparam int E_PC     = b_ceil(25);
  localparam int E_ACC    = b_ceil(35);
  localparam int E_ROWMAX = b_ceil(100000);

  function automatic logic [15:0] b_merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] be);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [9:0]  dram_addr;
  logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in;

  edo_page_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Device model and bench-side expectations.
  logic [15:0] dev_mem [0:63];
  logic [15:0] ref_mem [0:63];
  logic [9:0]  dev_row = '0, dev_col = '0;
  logic        p_ras = 1'b1, p_u = 1'b1, p_l = 1'b1, p_we = 1'b1;
  int          t_ras_fall = 0, t_ras_rise = 0, t_cas_fall = -1000;
  int          ras_opens = 0;
  bit          cur_write = 1'b0;
  logic [1:0]  cur_be = '0;
  logic [9:0]  cur_row = '0, cur_col = '0;

  assign dram_dq_in = !dram_oe_n ? dev_mem[{dev_row[1:0], dev_col[3:0]}] : 16'h0000;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        check(cyc - t_ras_rise >= E_RP, "R6", "precharge cycles", cyc - t_ras_rise, E_RP);
        check(dram_addr == cur_row, "R1", "row at row strobe", int'(dram_addr), int'(cur_row));
        dev_row = dram_addr;
        t_ras_fall = cyc;
        ras_opens++;
      end
      if (!p_ras && dram_ras_n) begin
        check(cyc - t_ras_fall >= E_RAS, "R7", "row active cycles", cyc - t_ras_fall, E_RAS);
        check(cyc - t_ras_fall <= E_ROWMAX, "R11", "row open cycles", cyc - t_ras_fall, E_ROWMAX);
        t_ras_rise = cyc;
      end
      if (p_u && p_l && !(dram_ucas_n && dram_lcas_n)) begin
        check(!dram_ras_n && (cyc - t_ras_fall >= E_RCD), "R5", "row to column cycles",
              cyc - t_ras_fall, E_RCD);
        if (t_cas_fall > t_ras_fall)
          check(cyc - t_cas_fall >= E_PC, "R8", "page cycle", cyc - t_cas_fall, E_PC);
        check(dram_addr == cur_col, "R1", "column at column strobe", int'(dram_addr), int'(cur_col));
        dev_col = dram_addr;
        if (cur_write) begin
          check({dram_ucas_n, dram_lcas_n} == ~cur_be, "R2", "write strobes",
                int'({dram_ucas_n, dram_lcas_n}), int'(~cur_be));
          check(!p_we && !dram_we_n && dram_dq_oe && dram_oe_n, "R4", "early write setup",
                int'({p_we, dram_we_n, dram_dq_oe, dram_oe_n}), 4'b0011);
          if (!dram_ucas_n) dev_mem[{dev_row[1:0], dev_col[3:0]}][15:8] = dram_dq_out[15:8];
          if (!dram_lcas_n) dev_mem[{dev_row[1:0], dev_col[3:0]}][7:0] = dram_dq_out[7:0];
        end else begin
          check({dram_ucas_n, dram_lcas_n} == 2'b00 && !dram_oe_n && dram_we_n && !dram_dq_oe,
                "R3", "read strobes and output enable",
                int'({dram_ucas_n, dram_lcas_n, dram_oe_n, dram_we_n, dram_dq_oe}), 5'b00010);
        end
        t_cas_fall = cyc;
      end
      if (!(p_u && p_l) && dram_ucas_n && dram_lcas_n)
        check(cyc - t_cas_fall >= E_CAS, "R7", "column low cycles", cyc - t_cas_fall, E_CAS);
      if (rsp_valid)
        check(cyc - t_cas_fall >= E_ACC, "R12", "sample latency", cyc - t_cas_fall, E_ACC);
    end
    p_ras = dram_ras_n; p_u = dram_ucas_n; p_l = dram_lcas_n; p_we = dram_we_n;
  end

  task automatic do_req(input bit wr, input logic [9:0] row, input logic [9:0] col,
                        input logic [1:0] be, input logic [15:0] d);
    bit exp_hit;
    int opens0;
    int idx;
    int guard;
    idx = int'({row[1:0], col[3:0]});
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_hit = !dram_ras_n && (dev_row == row);
    opens0 = ras_opens;
    cur_write = wr; cur_be = be; cur_row = row; cur_col = col;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      ref_mem[idx] = b_merge(ref_mem[idx], d, be);
    end else begin
      guard = 0;
      while (!rsp_valid && guard < 100) begin @(negedge clk); guard++; end
      check(rsp_valid && rsp_rdata == ref_mem[idx], "R12", "read data",
            int'(rsp_rdata), int'(ref_mem[idx]));
    end
    guard = 0;
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    if (exp_hit) check(ras_opens == opens0, "R9", "activations on open row", ras_opens - opens0, 0);
    else         check(ras_opens == opens0 + 1, "R10", "activations on miss", ras_opens - opens0, 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      check(1'b0, "watchdog", "run did not complete", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed_val;
    seed_val = $urandom(32'd5150);
    for (int i = 0; i < 64; i++) begin dev_mem[i] = '0; ref_mem[i] = '0; end
    repeat (4) @(negedge clk);
    // R13: strobes idle during reset
    check({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe} == 6'b111110,
          "R13", "strobes in reset",
          int'({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe}), 6'b111110);
    rst_n = 1'b1;
    t_ras_rise = cyc;
    @(negedge clk);
    check(req_ready && dram_ras_n && dram_ucas_n && dram_lcas_n && !dram_dq_oe, "R13",
          "idle after reset", int'(req_ready), 1);

    // R1/R10/R9: full word write then read, first a miss then a hit
    do_req(1'b1, 10'd1, 10'd3, 2'b11, 16'hA55A);
    do_req(1'b0, 10'd1, 10'd3, 2'b11, 16'h0);
    // R2: byte-masked writes merge into one word
    do_req(1'b1, 10'd1, 10'd5, 2'b11, 16'h1234);
    do_req(1'b1, 10'd1, 10'd5, 2'b10, 16'hBBFF);
    do_req(1'b1, 10'd1, 10'd5, 2'b01, 16'hFFCC);
    do_req(1'b0, 10'd1, 10'd5, 2'b11, 16'h0);
    // R10: alternating rows force close and reopen
    do_req(1'b1, 10'd2, 10'd7, 2'b11, 16'h0F0F);
    do_req(1'b0, 10'd1, 10'd3, 2'b11, 16'h0);
    do_req(1'b0, 10'd2, 10'd7, 2'b11, 16'h0);

    // R11: an idle open row is closed before the age limit
    repeat (E_ROWMAX + 20) @(negedge clk);
    check(dram_ras_n, "R11", "row closed after idle", int'(dram_ras_n), 1);
    do_req(1'b0, 10'd2, 10'd7, 2'b11, 16'h0);

    for (int n = 0; n < 300; n++) begin
      logic [9:0] r, c;
      logic [1:0] be;
      r = 10'($urandom_range(0, 3));
      c = 10'($urandom_range(0, 15));
      be = 2'($urandom_range(1, 3));
      if ($urandom_range(0, 1) == 1) do_req(1'b1, r, c, be, 16'($urandom));
      else                           do_req(1'b0, r, c, 2'b11, 16'h0);
    end

    done = 1'b1;
    finish_run();
  end
endmodule